// File: doc/BRIEF.md
# Width-Split Masked Memory Wrapper

This block presents one wide single-port synchronous memory built from several narrower library SRAM instances placed side by side. Every instance sees the same clock, reset and address. The wrapper cuts the logical write word into lane slices and joins the lane read words back into one logical read word. It also turns the logical write mask into whatever each library instance accepts.

The logical memory may have a write mask of some granularity, or none. The library SRAM may have a bit mask, a coarser mask, or no mask. There are four cases:

- Both sides have a mask: each library mask bit is wired to the logical mask bit that covers it.
- Only the logical side has a mask: that mask gates the write enable of each lane.
- Only the library has a mask: every library mask bit is held at one.
- Neither side has a mask: the plain write enable is used.

An unsupported pairing of granularities stops elaboration with an error. The library SRAM is a behavioural model inside the project.

Top module: `mw_split_mem`

## Requirements
- R1: The block uses ceil(MEM_W / LIB_W) lanes. Lane i stores logical bits starting at LIB_W*i. The last lane holds only the remaining bits. A full-mask write followed by a read returns every bit unchanged, including the bits of the partial top lane.
- R2: Read data appears on `rdata` one clock edge after the address is sampled. Reading the location that is being written in the same cycle returns its previous contents.
- R3: While the address is held and no write occurs, `rdata` keeps its value from cycle to cycle.
- R4: When both granularities are equal (G), logical mask bit k enables exactly logical bits k*G to k*G+G-1.
- R5: With a one-bit library mask granularity, logical bit b is written only when logical mask bit b / MEM_GRAN is one.
- R6: With a library SRAM that has no mask, a lane is written only when `wen` is one and the logical mask bit covering the lane's lowest bit is one. Each lane lies inside one mask lane.
- R7: With no logical mask (MEM_GRAN = 0), `wmask` has no effect. Every write stores the whole word, and all library mask bits are driven to one.
- R8: When neither side has a mask, `wen` alone writes the whole word.
- R9: A write with an all-zero mask leaves the location unchanged. In a partial-mask write, the masked-off lanes keep their old contents.
- R10: While `rst` is one, `rdata` is cleared to zero at each clock edge.
- R11: While `wen` is zero, no lane is enabled for writing, whatever `wdata` and `wmask` carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by all lanes |
| rst | input | 1 | Synchronous active-high reset of the read register |
| addr | input | ADDR_W | Word address, shared by all lanes |
| wen | input | 1 | Write enable |
| wdata | input | MEM_W | Logical write word |
| wmask | input | MEM_MB | Logical write mask, bit k covers bits k*MEM_GRAN upward; one unused bit when MEM_GRAN is 0 |
| rdata | output | MEM_W | Logical read word, registered |

## Verification
The read-hold property assumes that memory contents are defined before a location is read with the address held. The bench therefore writes every address with a full mask before any read-only traffic, and it deasserts reset with the address parked on a location that is written in the very next cycle. The mask properties assume no relation between `wdata` and `wmask`, so the stimulus draws them independently, including all-zero and all-one masks. Five configurations, one per mask-translation case plus a second library-mask case, share the same address, data and mask sequence.

// File: rtl/mw_pkg.sv
package mw_pkg;

    typedef enum logic [1:0] {
        MM_NONE     = 2'd0,
        MM_LIB_ONLY = 2'd1,
        MM_MEM_ONLY = 2'd2,
        MM_BOTH     = 2'd3
    } mask_mode_e;

    function automatic mask_mode_e mask_mode(input int mem_gran, input int lib_gran);
        if (mem_gran == 0 && lib_gran == 0) return MM_NONE;
        if (mem_gran == 0)                  return MM_LIB_ONLY;
        if (lib_gran == 0)                  return MM_MEM_ONLY;
        return MM_BOTH;
    endfunction

    function automatic int div_ceil(input int a, input int b);
        return (a + b - 1) / b;
    endfunction

    function automatic int lane_count(input int mem_w, input int lib_w);
        return div_ceil(mem_w, lib_w);
    endfunction

    function automatic int lane_base(input int idx, input int lib_w);
        return idx * lib_w;
    endfunction

    function automatic int lane_width(input int idx, input int mem_w, input int lib_w);
        int rem;
        rem = mem_w - idx * lib_w;
        return (rem < lib_w) ? rem : lib_w;
    endfunction

    function automatic int mask_bits(input int w, input int gran);
        return (gran == 0) ? 1 : div_ceil(w, gran);
    endfunction

    function automatic int phys_gran(input int lib_w, input int lib_gran);
        return (lib_gran == 0) ? lib_w : lib_gran;
    endfunction

    function automatic int mask_src(input int base, input int x, input int lib_gran,
                                    input int mem_gran);
        return (base + x * lib_gran) / mem_gran;
    endfunction

endpackage

// File: rtl/mw_lib_sram.sv
module mw_lib_sram #(
    parameter int W     = 8,
    parameter int GRAN  = 1,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int MB   = (W + GRAN - 1) / GRAN
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [MB-1:0] mask,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout
);

    logic [W-1:0] store [DEPTH];
    logic [W-1:0] bit_en;

    always_comb begin
        for (int b = 0; b < W; b++) begin
            bit_en[b] = mask[b / GRAN];
        end
    end

    always_ff @(posedge clk) begin
        if (we) begin
            store[addr] <= (store[addr] & ~bit_en) | (din & bit_en);
        end
        if (rst) begin
            dout <= '0;
        end else begin
            dout <= store[addr];
        end
    end

endmodule

// File: rtl/mw_lane_ctrl.sv
module mw_lane_ctrl
    import mw_pkg::*;
#(
    parameter int MEM_W    = 20,
    parameter int LIB_W    = 8,
    parameter int MEM_GRAN = 4,
    parameter int LIB_GRAN = 1,
    parameter int IDX      = 0,
    localparam int MEM_MB  = mask_bits(MEM_W, MEM_GRAN),
    localparam int LIB_MB  = mask_bits(LIB_W, LIB_GRAN)
) (
    input  logic              wen,
    input  logic [MEM_MB-1:0] wmask,
    output logic [LIB_MB-1:0] lib_mask,
    output logic              lib_we
);

    localparam mask_mode_e MODE = mask_mode(MEM_GRAN, LIB_GRAN);
    localparam int BASE = lane_base(IDX, LIB_W);

    logic unused_mask;
    assign unused_mask = ^wmask;

    if (MODE == MM_BOTH) begin : g_both
        for (genvar x = 0; x < LIB_MB; x++) begin : g_bit
            if (BASE + x * LIB_GRAN < MEM_W) begin : g_live
                localparam int SRC = mask_src(BASE, x, LIB_GRAN, MEM_GRAN);
                assign lib_mask[x] = wmask[SRC];
            end else begin : g_pad
                assign lib_mask[x] = 1'b0;
            end
        end
        assign lib_we = wen;
    end else if (MODE == MM_MEM_ONLY) begin : g_gate
        localparam int SRC = BASE / MEM_GRAN;
        assign lib_mask = '1;
        assign lib_we   = wen & wmask[SRC];
    end else begin : g_plain
        assign lib_mask = '1;
        assign lib_we   = wen;
    end

endmodule

// File: rtl/mw_split_mem.sv
module mw_split_mem
    import mw_pkg::*;
#(
    parameter int MEM_W    = 20,
    parameter int LIB_W    = 8,
    parameter int MEM_GRAN = 4,
    parameter int LIB_GRAN = 1,
    parameter int DEPTH    = 16,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int MEM_MB  = mask_bits(MEM_W, MEM_GRAN)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wen,
    input  logic [MEM_W-1:0]  wdata,
    input  logic [MEM_MB-1:0] wmask,
    output logic [MEM_W-1:0]  rdata
);

    localparam int LANES  = lane_count(MEM_W, LIB_W);
    localparam int LIB_MB = mask_bits(LIB_W, LIB_GRAN);
    localparam int PGRAN  = phys_gran(LIB_W, LIB_GRAN);
    localparam mask_mode_e MODE = mask_mode(MEM_GRAN, LIB_GRAN);

    typedef struct packed {
        logic              we;
        logic [LIB_MB-1:0] mask;
        logic [LIB_W-1:0]  din;
    } lane_req_t;

    lane_req_t                req  [LANES];
    logic [LIB_W-1:0]         dout [LANES];
    logic [LANES-1:0]         lane_we_vec;
    logic [LANES*LIB_MB-1:0]  lane_mask_vec;

    if (MODE == MM_BOTH) begin : g_chk_both
        if (LIB_GRAN > MEM_GRAN || (MEM_GRAN % LIB_GRAN) != 0 || (LIB_W % LIB_GRAN) != 0) begin : g_bad
            $error("library mask granularity must divide the logical mask granularity and the lane width");
        end
    end
    if (MODE == MM_MEM_ONLY) begin : g_chk_gate
        if ((MEM_GRAN % LIB_W) != 0) begin : g_bad
            $error("a lane without mask must lie inside one logical mask lane");
        end
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam int BASE = lane_base(i, LIB_W);
        localparam int WID  = lane_width(i, MEM_W, LIB_W);

        logic [LIB_MB-1:0] l_mask;
        logic              l_we;
        logic [LIB_W-1:0]  l_din;

        mw_lane_ctrl #(
            .MEM_W    (MEM_W),
            .LIB_W    (LIB_W),
            .MEM_GRAN (MEM_GRAN),
            .LIB_GRAN (LIB_GRAN),
            .IDX      (i)
        ) u_ctrl (
            .wen      (wen),
            .wmask    (wmask),
            .lib_mask (l_mask),
            .lib_we   (l_we)
        );

        if (WID == LIB_W) begin : g_full
            assign l_din = wdata[BASE +: LIB_W];
            assign rdata[BASE +: LIB_W] = dout[i];
        end else begin : g_part
            logic unused_hi;
            assign l_din = {{(LIB_W - WID){1'b0}}, wdata[BASE +: WID]};
            assign rdata[BASE +: WID] = dout[i][WID-1:0];
            assign unused_hi = ^dout[i][LIB_W-1:WID];
        end

        assign req[i] = '{we: l_we, mask: l_mask, din: l_din};
        assign lane_we_vec[i] = req[i].we;
        assign lane_mask_vec[i*LIB_MB +: LIB_MB] = req[i].mask;

        mw_lib_sram #(
            .W     (LIB_W),
            .GRAN  (PGRAN),
            .DEPTH (DEPTH)
        ) u_sram (
            .clk  (clk),
            .rst  (rst),
            .addr (addr),
            .we   (req[i].we),
            .mask (req[i].mask),
            .din  (req[i].din),
            .dout (dout[i])
        );
    end

endmodule

// File: rtl/mw_split_mem_chk.sv
module mw_split_mem_chk
    import mw_pkg::*;
#(
    parameter int MEM_W    = 20,
    parameter int LIB_W    = 8,
    parameter int MEM_GRAN = 4,
    parameter int LIB_GRAN = 1,
    parameter int DEPTH    = 16,
    localparam int ADDR_W  = $clog2(DEPTH),
    localparam int MEM_MB  = mask_bits(MEM_W, MEM_GRAN),
    localparam int LANES   = lane_count(MEM_W, LIB_W),
    localparam int LIB_MB  = mask_bits(LIB_W, LIB_GRAN)
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ADDR_W-1:0]       addr,
    input logic                    wen,
    input logic [MEM_MB-1:0]       wmask,
    input logic [MEM_W-1:0]        rdata,
    input logic [LANES-1:0]        lane_we_vec,
    input logic [LANES*LIB_MB-1:0] lane_mask_vec
);

    // R11: an idle cycle enables no lane
    a_r11_idle_no_write: assert property (@(posedge clk) disable iff (rst)
        !wen |-> (lane_we_vec == '0));

    // R1: a write with every mask bit set enables every lane
    a_r1_full_write_all_lanes: assert property (@(posedge clk) disable iff (rst)
        (wen && (&wmask)) |-> (&lane_we_vec));

    // R3: held address without writes keeps the read word
    a_r3_hold_read: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && !$past(wen) && !wen && (addr == $past(addr))) |=> $stable(rdata));

    if (MEM_GRAN != 0) begin : g_masked
        for (genvar i = 0; i < LANES; i++) begin : g_lane
            // R9: an all-zero logical mask reaches no library bit
            a_r9_zero_mask_blocks: assert property (@(posedge clk) disable iff (rst)
                (wen && (wmask == '0)) |->
                    !(lane_we_vec[i] && (|lane_mask_vec[i*LIB_MB +: LIB_MB])));
        end
    end

endmodule

bind mw_split_mem mw_split_mem_chk #(
    .MEM_W    (MEM_W),
    .LIB_W    (LIB_W),
    .MEM_GRAN (MEM_GRAN),
    .LIB_GRAN (LIB_GRAN),
    .DEPTH    (DEPTH)
) chk_i (
    .clk           (clk),
    .rst           (rst),
    .addr          (addr),
    .wen           (wen),
    .wmask         (wmask),
    .rdata         (rdata),
    .lane_we_vec   (lane_we_vec),
    .lane_mask_vec (lane_mask_vec)
);

// File: tb/mw_split_mem_tb.sv
module mw_split_mem_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic        wen;
    logic [19:0] wd;
    logic [4:0]  wm;

    logic [19:0] ya;
    logic [15:0] yb, yc;
    logic [11:0] yd, ye;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    // A: bit-granular library mask under a 4-bit logical mask (R5)
    mw_split_mem #(.MEM_W(20), .LIB_W(8), .MEM_GRAN(4), .LIB_GRAN(1), .DEPTH(16)) dut_i (
        .clk(clk), .rst(rst), .addr(addr), .wen(wen), .wdata(wd), .wmask(wm), .rdata(ya));
    // B: equal granularity (R4)
    mw_split_mem #(.MEM_W(16), .LIB_W(8), .MEM_GRAN(8), .LIB_GRAN(8), .DEPTH(16)) dut_b (
        .clk(clk), .rst(rst), .addr(addr), .wen(wen), .wdata(wd[15:0]), .wmask(wm[1:0]), .rdata(yb));
    // C: library without mask, write-enable gating (R6)
    mw_split_mem #(.MEM_W(16), .LIB_W(4), .MEM_GRAN(8), .LIB_GRAN(0), .DEPTH(16)) dut_c (
        .clk(clk), .rst(rst), .addr(addr), .wen(wen), .wdata(wd[15:0]), .wmask(wm[1:0]), .rdata(yc));
    // D: logical side without mask (R7)
    mw_split_mem #(.MEM_W(12), .LIB_W(8), .MEM_GRAN(0), .LIB_GRAN(2), .DEPTH(16)) dut_d (
        .clk(clk), .rst(rst), .addr(addr), .wen(wen), .wdata(wd[11:0]), .wmask(wm[0:0]), .rdata(yd));
    // E: no mask anywhere (R8)
    mw_split_mem #(.MEM_W(12), .LIB_W(5), .MEM_GRAN(0), .LIB_GRAN(0), .DEPTH(16)) dut_e (
        .clk(clk), .rst(rst), .addr(addr), .wen(wen), .wdata(wd[11:0]), .wmask(wm[0:0]), .rdata(ye));

    logic [19:0] ra [16];
    logic [19:0] rb [16];
    logic [19:0] rc [16];
    logic [19:0] rd [16];
    logic [19:0] re [16];
    logic [19:0] ea, eb, ec, ed, ee;
    logic        pend = 1'b0;
    string       ptag;

    function automatic logic [19:0] bmask(input logic [4:0] m, input int gran, input int w);
        logic [19:0] r;
        for (int b = 0; b < 20; b++) begin
            r[b] = (b < w) && ((gran == 0) || m[b / gran]);
        end
        return r;
    endfunction

    function automatic logic [19:0] apply(input logic [19:0] old, input logic [19:0] d,
                                          input logic [19:0] bm);
        return (old & ~bm) | (d & bm);
    endfunction

    task automatic chk(input string tag, input string cfg, input logic [19:0] got,
                       input logic [19:0] exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s cfg %s: got %h expected %h", tag, cfg, got, exp);
        end
    endtask

    task automatic flush();
        if (pend) begin
            chk({ptag, "/R5"}, "A", ya, ea);
            chk({ptag, "/R4"}, "B", {4'h0, yb}, eb);
            chk({ptag, "/R6"}, "C", {4'h0, yc}, ec);
            chk({ptag, "/R7"}, "D", {8'h0, yd}, ed);
            chk({ptag, "/R8"}, "E", {8'h0, ye}, ee);
        end
        pend = 1'b0;
    endtask

    task automatic step(input logic [3:0] a, input logic w, input logic [19:0] d,
                        input logic [4:0] m, input string tag);
        @(negedge clk);
        flush();
        addr = a; wen = w; wd = d; wm = m;
        ea = ra[a]; eb = rb[a]; ec = rc[a]; ed = rd[a]; ee = re[a];
        if (w) begin
            ra[a] = apply(ra[a], d, bmask(m, 4, 20));
            rb[a] = apply(rb[a], d, bmask(m, 8, 16));
            rc[a] = apply(rc[a], d, bmask(m, 8, 16));
            rd[a] = apply(rd[a], d, bmask(m, 0, 12));
            re[a] = apply(re[a], d, bmask(m, 0, 12));
        end
        ptag = tag;
        pend = 1'b1;
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: run did not complete, got timeout expected finish");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; addr = '0; wen = 1'b0; wd = '0; wm = '0;
        repeat (3) @(negedge clk);
        // R10: read register cleared during reset
        chk("R10", "A", ya, 20'h0);
        chk("R10", "B", {4'h0, yb}, 20'h0);
        chk("R10", "C", {4'h0, yc}, 20'h0);
        chk("R10", "D", {8'h0, yd}, 20'h0);
        chk("R10", "E", {8'h0, ye}, 20'h0);
        wen = 1'b1; wd = 20'h0; wm = 5'h1f;
        rst = 1'b0;

        // R1: fill every address with a full mask, then read back
        for (int a = 0; a < 16; a++) begin
            step(4'(a), 1'b1, {4'(a), ~4'(a), 4'(a), 4'(a) ^ 4'h5, ~4'(a)}, 5'h1f, "R1");
        end
        for (int a = 0; a < 16; a++) begin
            step(4'(a), 1'b0, 20'($urandom), 5'($urandom), "R1");
        end

        // R2: random masked traffic, read-during-write returns old data
        for (int k = 0; k < 1500; k++) begin
            step(4'($urandom), 1'($urandom), 20'($urandom), 5'($urandom), "R2");
        end

        // R9: partial and zero masks keep masked-off lanes
        step(4'd3, 1'b1, 20'hfffff, 5'h1f, "R9");
        step(4'd3, 1'b1, 20'h00000, 5'h01, "R9");
        step(4'd3, 1'b1, 20'h00000, 5'h00, "R9");
        step(4'd3, 1'b0, 20'h12345, 5'h00, "R9");
        step(4'd3, 1'b0, 20'h0,     5'h00, "R9");

        // R11: idle cycles with busy data and mask buses write nothing
        step(4'd7, 1'b0, 20'habcde, 5'h1f, "R11");
        step(4'd7, 1'b0, 20'h54321, 5'h0a, "R11");
        step(4'd7, 1'b0, 20'h00000, 5'h00, "R11");

        // R3: held address without writes keeps the read word
        step(4'd9, 1'b0, 20'h0, 5'h0, "R3");
        step(4'd9, 1'b0, 20'h0, 5'h0, "R3");
        step(4'd9, 1'b0, 20'h0, 5'h0, "R3");

        @(negedge clk);
        flush();
        wen = 1'b0;
        summary();
        $finish;
    end

endmodule